// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a two-wire synchronous link in which it is always the clock master. One wire carries the data. The block drives it when transmitting and samples it when receiving, so the pad side is split into an output value, an output enable and an input value. The second wire carries a shift clock that the block generates. It rests high between transfers.

A transfer is started by a single-cycle strobe: one for transmit, which loads the parallel byte, and one for receive. Every bit takes a fixed number of oscillator clocks (12 by default). Outgoing data changes 2 clocks after each shift-clock rising edge, so it is settled 10 clocks before the next rising edge. Incoming data is taken on the same clock edge that raises the shift clock.

After eight bits, least significant first, the block sets a done flag for the direction used. The flag stays set until its clear input is pulsed. A received byte appears on a parallel output when a receive transfer completes.

Top module: `ssp_sync_serial`

## Requirements
- R1: After reset the shift clock is high, the data output enable is low, the data output is high, both done flags are 0 and the received byte is 0x00.
- R2: During a transfer, each bit spans 12 clocks, numbered phase 0 to 11. Phase 0 of the first bit is the first cycle after the accepting strobe edge. The shift clock is low in phases 4 to 9 and high in phases 10, 11 and 0 to 3. It stays high whenever no transfer is active.
- R3: A transmit transfer drives bit k of the loaded byte (k = 0 first) from phase 0 to phase 11 of bit k. The output enable is high for exactly the 96 cycles of a transmit transfer.
- R4: A receive transfer stores the data input value present at the edge that ends phase 9 of bit k as bit k of the received byte. Values in other phases have no effect. The received byte output changes only when a receive transfer completes.
- R5: A transfer lasts 96 cycles. The done flag of its direction reads 1 starting in the cycle after phase 11 of bit 7.
- R6: A done flag stays 1 until its clear input is high at a clock edge. If completion and clear fall on the same edge, the flag ends at 1.
- R7: Transmit or receive strobes given while a transfer is active are ignored: the running transfer, its data and its length are unaffected.
- R8: If both strobes are high at the same edge while idle, a transmit transfer starts and the receive strobe is dropped.
- R9: While no transmit transfer is active, the output enable is low and the data output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte loaded by a transmit strobe |
| tx_start_i | input | 1 | Transmit strobe |
| rx_start_i | input | 1 | Receive strobe |
| tx_done_clr_i | input | 1 | Clears the transmit done flag |
| rx_done_clr_i | input | 1 | Clears the receive done flag |
| sdata_i | input | 1 | Data wire, input value |
| sdata_o | output | 1 | Data wire, output value |
| sdata_oe_o | output | 1 | Data wire, output enable |
| sclk_o | output | 1 | Shift clock |
| rx_data_o | output | 8 | Last received byte |
| tx_done_o | output | 1 | Transmit done flag |
| rx_done_o | output | 1 | Receive done flag |

## Verification
The completion of a transfer and the clear input of that direction's done flag can land on the same clock edge. The bench tracks the phase of the running transfer in its reference model and raises the clear input exactly during phase 11 of bit 7, so that the edge which sets the flag also sees the clear. The flag must read 1 afterwards. A second clear pulse given alone must then bring it to 0. In the same way, strobes given in mid-transfer and both strobes given together are checked against the model on every clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } ssp_dir_e;
endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
  parameter int unsigned CLKS_PER_BIT = 12,
  parameter int unsigned HOLD_CLKS    = 2,
  parameter int unsigned NUM_BITS     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic sample_o,
  output logic shift_o,
  output logic done_o,
  output logic sclk_o
);
  localparam int unsigned PH_W      = $clog2(CLKS_PER_BIT);
  localparam int unsigned BIT_W     = $clog2(NUM_BITS);
  localparam int unsigned RISE_PH   = CLKS_PER_BIT - HOLD_CLKS;
  localparam int unsigned LOW_CLKS  = CLKS_PER_BIT / 2;
  localparam int unsigned LOW_FIRST = RISE_PH - LOW_CLKS;
  localparam logic [PH_W-1:0]  LAST_PH   = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [PH_W-1:0]  SAMPLE_PH = PH_W'(RISE_PH - 1);
  localparam logic [PH_W-1:0]  LOW_LO    = PH_W'(LOW_FIRST);
  localparam logic [PH_W-1:0]  LOW_HI    = PH_W'(RISE_PH - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(NUM_BITS - 1);

  logic             busy_q;
  logic [PH_W-1:0]  ph_q;
  logic [BIT_W-1:0] bit_q;
  logic             ph_wrap;

  assign ph_wrap = busy_q && (ph_q == LAST_PH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (ph_wrap) begin
        ph_q <= '0;
        if (bit_q == LAST_BIT) busy_q <= 1'b0;
        else                   bit_q  <= bit_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign sample_o = busy_q && (ph_q == SAMPLE_PH);
  assign shift_o  = ph_wrap;
  assign done_o   = ph_wrap && (bit_q == LAST_BIT);
  // low window ends one phase before the rising phase
  assign sclk_o   = !(busy_q && (ph_q >= LOW_LO) && (ph_q <= LOW_HI));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  ssp_pkg::ssp_dir_e dir_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              sdata_i,
  output logic              ser_o,
  output logic [DATA_W-1:0] par_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= load_data_i;
    end else if (dir_i == ssp_pkg::DIR_TX) begin
      if (shift_i) sh_q <= {1'b1, sh_q[DATA_W-1:1]};
    end else begin
      if (sample_i) sh_q <= {sdata_i, sh_q[DATA_W-1:1]};
    end
  end

  assign ser_o = sh_q[0];
  assign par_o = sh_q;
endmodule

// File: rtl/ssp_flag.sv
module ssp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/ssp_sync_serial.sv
module ssp_sync_serial #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLKS_PER_BIT = 12,
  parameter int unsigned HOLD_CLKS    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_start_i,
  input  logic              rx_start_i,
  input  logic              tx_done_clr_i,
  input  logic              rx_done_clr_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_done_o,
  output logic              rx_done_o
);
  import ssp_pkg::*;

  logic              busy, sample, shift, done, ser;
  logic              tx_go, rx_go, start;
  logic [DATA_W-1:0] par;
  logic [DATA_W-1:0] rx_data_q;
  ssp_dir_e          dir_q;

  // transmit wins a tie, strobes are dropped while busy
  assign tx_go = tx_start_i && !busy;
  assign rx_go = rx_start_i && !tx_start_i && !busy;
  assign start = tx_go || rx_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dir_q <= DIR_RX;
    else if (start) dir_q <= tx_go ? DIR_TX : DIR_RX;
  end

  ssp_bit_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .HOLD_CLKS   (HOLD_CLKS),
    .NUM_BITS    (DATA_W)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .sample_o(sample),
    .shift_o (shift),
    .done_o  (done),
    .sclk_o  (sclk_o)
  );

  ssp_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_data_i(tx_go ? tx_data_i : '0),
    .dir_i      (dir_q),
    .sample_i   (sample),
    .shift_i    (shift),
    .sdata_i    (sdata_i),
    .ser_o      (ser),
    .par_o      (par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rx_data_q <= '0;
    else if (done && dir_q == DIR_RX) rx_data_q <= par;
  end

  ssp_flag i_tx_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (done && dir_q == DIR_TX),
    .clr_i (tx_done_clr_i),
    .flag_o(tx_done_o)
  );

  ssp_flag i_rx_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (done && dir_q == DIR_RX),
    .clr_i (rx_done_clr_i),
    .flag_o(rx_done_o)
  );

  assign sdata_oe_o = busy && (dir_q == DIR_TX);
  assign sdata_o    = sdata_oe_o ? ser : 1'b1;
  assign rx_data_o  = rx_data_q;
endmodule

// File: rtl/ssp_sync_serial_chk.sv
module ssp_sync_serial_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_done_clr_i,
  input logic rx_done_clr_i,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic sclk_o,
  input logic tx_done_o,
  input logic rx_done_o
);
  // R3: data holds in the cycle after a rising shift-clock edge
  assert_hold_after_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && sdata_oe_o) |=> $stable(sdata_o));

  // R9: released line reads high
  assert_idle_line_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> sdata_o);

  // R2: the low window is longer than one cycle
  assert_low_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |=> !sclk_o);

  // R6: a set flag survives without a clear
  assert_tx_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o && !tx_done_clr_i) |=> tx_done_o);

  assert_rx_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !rx_done_clr_i) |=> rx_done_o);

  // R8: one transfer at a time, so both flags never rise together
  assert_single_direction_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(tx_done_o) && $rose(rx_done_o)));

  // R5: completion leaves the shift clock at its idle level
  assert_done_idle_clock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_done_o) || $rose(rx_done_o)) |-> sclk_o);
endmodule

bind ssp_sync_serial ssp_sync_serial_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_done_clr_i(tx_done_clr_i),
  .rx_done_clr_i(rx_done_clr_i),
  .sdata_o      (sdata_o),
  .sdata_oe_o   (sdata_oe_o),
  .sclk_o       (sclk_o),
  .tx_done_o    (tx_done_o),
  .rx_done_o    (rx_done_o)
);

// File: tb/test_ssp_sync_serial.sv
`timescale 1ns/1ps
module test_ssp_sync_serial;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_start_i = 1'b0, rx_start_i = 1'b0;
  logic       tx_done_clr_i = 1'b0, rx_done_clr_i = 1'b0;
  logic       sdata_i = 1'b1;
  logic       sdata_o, sdata_oe_o, sclk_o, tx_done_o, rx_done_o;
  logic [7:0] rx_data_o;

  ssp_sync_serial i_ssp_sync_serial (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // reference model: cycle counter from the accepting edge
  bit         m_busy, m_tx, m_txd, m_rxd;
  int         m_t;
  logic [7:0] m_byte, m_acc, m_rx;
  logic [7:0] rx_pat = 8'h00;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_tx = 0; m_txd = 0; m_rxd = 0; m_t = 0;
      m_byte = 0; m_acc = 0; m_rx = 0;
    end else begin
      bit set_t, set_r;
      set_t = 0; set_r = 0;
      if (!m_busy) begin
        if (tx_start_i) begin
          m_busy = 1; m_tx = 1; m_byte = tx_data_i; m_t = 0;
        end else if (rx_start_i) begin
          m_busy = 1; m_tx = 0; m_acc = 0; m_t = 0;
        end
      end else begin
        if (!m_tx && (m_t % 12) == 9) m_acc[m_t / 12] = sdata_i;
        if (m_t == 95) begin
          m_busy = 0;
          if (m_tx) set_t = 1;
          else begin set_r = 1; m_rx = m_acc; end
        end else m_t++;
      end
      if (set_t) m_txd = 1; else if (tx_done_clr_i) m_txd = 0;
      if (set_r) m_rxd = 1; else if (rx_done_clr_i) m_rxd = 0;
    end
  end

  // line driver: correct bit only in the sampling phase
  always @(negedge clk_i) begin
    if (m_busy && !m_tx && (m_t % 12) == 9) sdata_i <= rx_pat[m_t / 12];
    else                                     sdata_i <= ~rx_pat[(m_t / 12) % 8];
  end

  // per-cycle comparison and independent capture of sent bits
  logic [7:0] cap = 8'h00;
  logic       prev_sclk = 1'b1;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int  ph;
      bit  e_sclk, e_oe, e_sd;
      ph     = m_t % 12;
      e_sclk = !(m_busy && ph >= 4 && ph <= 9);
      e_oe   = m_busy && m_tx;
      e_sd   = e_oe ? m_byte[m_t / 12] : 1'b1;
      chk(sclk_o == e_sclk, "R2", "sclk", int'(sclk_o), int'(e_sclk));
      chk(sdata_oe_o == e_oe, "R3", "oe", int'(sdata_oe_o), int'(e_oe));
      chk(sdata_o == e_sd, e_oe ? "R3" : "R9", "sdata", int'(sdata_o), int'(e_sd));
      chk(rx_data_o == m_rx, "R4", "rx_data", int'(rx_data_o), int'(m_rx));
      chk(tx_done_o == m_txd, "R5", "tx_done", int'(tx_done_o), int'(m_txd));
      chk(rx_done_o == m_rxd, "R6", "rx_done", int'(rx_done_o), int'(m_rxd));
      if (sclk_o && !prev_sclk) cap = {sdata_o, cap[7:1]};
      prev_sclk = sclk_o;
    end
  end

  task automatic strobe(input bit t, input bit r, input logic [7:0] d);
    @(negedge clk_i);
    tx_data_i = d; tx_start_i = t; rx_start_i = r;
    @(negedge clk_i);
    tx_start_i = 0; rx_start_i = 0;
  endtask

  // returns cycles from the first transfer cycle until a done flag reads 1
  task automatic wait_done(output int k);
    k = 0;
    while (!(tx_done_o || rx_done_o) && k < 500) begin
      @(negedge clk_i); k++;
    end
  endtask

  task automatic clear_flags();
    @(negedge clk_i);
    tx_done_clr_i = 1; rx_done_clr_i = 1;
    @(negedge clk_i);
    tx_done_clr_i = 0; rx_done_clr_i = 0;
  endtask

  task automatic send(input logic [7:0] d);
    int k;
    clear_flags();
    strobe(1, 0, d);
    wait_done(k);
    chk(k == 96, "R5", "tx length", k, 96);
    chk(cap == d, "R3", "tx byte lsb first", int'(cap), int'(d));
    chk(tx_done_o == 1, "R5", "tx_done set", int'(tx_done_o), 1);
  endtask

  task automatic receive(input logic [7:0] d);
    int k;
    clear_flags();
    rx_pat = d;
    strobe(0, 1, 8'h00);
    wait_done(k);
    chk(k == 96, "R5", "rx length", k, 96);
    chk(rx_data_o == d, "R4", "rx byte", int'(rx_data_o), int'(d));
    chk(rx_done_o == 1 && tx_done_o == 0, "R4", "rx_done only", int'({tx_done_o, rx_done_o}), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk_i);
    chk(sclk_o == 1 && sdata_oe_o == 0 && sdata_o == 1, "R1", "idle pins in reset",
        int'({sclk_o, sdata_oe_o, sdata_o}), 5);
    rst_ni = 1;
    @(negedge clk_i);
    chk(tx_done_o == 0 && rx_done_o == 0, "R1", "flags after reset", int'({tx_done_o, rx_done_o}), 0);
    chk(rx_data_o == 8'h00, "R1", "rx_data after reset", int'(rx_data_o), 0);

    send(8'hA5);
    send(8'h00);
    send(8'hFF);
    receive(8'h3C);
    receive(8'hC1);

    // R6: flag sticks, then a lone clear drops it
    repeat (20) @(negedge clk_i);
    chk(rx_done_o == 1, "R6", "flag sticky", int'(rx_done_o), 1);
    @(negedge clk_i); rx_done_clr_i = 1;
    @(negedge clk_i); rx_done_clr_i = 0;
    chk(rx_done_o == 0, "R6", "flag cleared", int'(rx_done_o), 0);

    // R7: strobes in mid-transfer ignored
    clear_flags();
    strobe(1, 0, 8'h0F);
    repeat (30) @(negedge clk_i);
    strobe(1, 1, 8'hF0);
    wait_done(k);
    chk(k == 96 - 32, "R7", "length unaffected", k, 64);
    chk(cap == 8'h0F, "R7", "tx data unaffected", int'(cap), 8'h0F);
    chk(rx_done_o == 0, "R7", "no rx started", int'(rx_done_o), 0);
    repeat (3) @(negedge clk_i);
    chk(sdata_oe_o == 0 && sclk_o == 1, "R7", "idle after ignored strobe", int'({sdata_oe_o, sclk_o}), 1);

    // R8: both strobes together
    clear_flags();
    strobe(1, 1, 8'h81);
    chk(sdata_oe_o == 1, "R8", "tx chosen", int'(sdata_oe_o), 1);
    wait_done(k);
    chk(tx_done_o == 1 && rx_done_o == 0, "R8", "only tx done", int'({tx_done_o, rx_done_o}), 2);
    chk(cap == 8'h81, "R8", "tx byte", int'(cap), 8'h81);

    // R6: clear on the completing edge, set wins
    clear_flags();
    rx_pat = 8'h5A;
    strobe(0, 1, 8'h00);
    while (!(m_busy && m_t == 95)) @(negedge clk_i);
    rx_done_clr_i = 1;
    @(negedge clk_i);
    rx_done_clr_i = 0;
    chk(rx_done_o == 1, "R6", "set beats clear", int'(rx_done_o), 1);
    chk(rx_data_o == 8'h5A, "R4", "rx byte at collision", int'(rx_data_o), 8'h5A);
    @(negedge clk_i); rx_done_clr_i = 1;
    @(negedge clk_i); rx_done_clr_i = 0;
    chk(rx_done_o == 0, "R6", "later clear", int'(rx_done_o), 0);

    repeat (5) @(negedge clk_i);
    report();
  end
endmodule